// File: doc/BRIEF.md
# Eight-to-one double-rate lane serializer

This block turns an 8-bit parallel word into a serial stream for one output lane. The serial side runs at double data rate, so one bit leaves on every edge of the fast serial clock. The block is written against a bit-rate clock `clk`, with one cycle for each serial half-period. Even bit slots stand for rising serial-clock edges and odd slots for falling ones. The parallel load clock `div_clk` runs at one quarter of the serial clock, which is eight `clk` cycles per period. It is sampled in the `clk` domain, and each of its rising edges captures `d_in` into a holding register.

After a synchronous reset the serial output sits at a configurable value and nothing moves. The first load edge starts the shift controller. The controller first flushes the eight zero bits left in its shift register, and only then sends the first captured word. From then on it always finishes a complete word before it moves the holding register into the shift register. If no new word is loaded, the held word goes out again. A constant input pattern with a single load edge therefore gives a free-running waveform such as a clock. The output clock-enable acts only on the serial output register and has no effect on loading.

Top module: `ddr_word_serializer`

## Requirements
- R1: `d_in` is captured only at a rising edge of `div_clk` (low at one `clk` edge, high at the next). While `div_clk` stays high or stays low, changes on `d_in` have no effect on the output.
- R2: During reset, and after reset until the first load, `oq` equals the parameter `OQ_RST` (default 0).
- R3: The first load after reset starts the controller. Counting `clk` edges after the load edge, `oq` is 0 after edges 1 to 8 (the flush) and carries the first data bit after edge 9.
- R4: Bits go out in order `d_in[0]` to `d_in[7]`, one per `clk` edge. `d_in[0]` goes out in an even (rising serial edge) slot and `d_in[7]` in an odd (falling serial edge) slot. A word loaded at edge L occupies the outputs after edges L+9 to L+16 when loads arrive every eight cycles.
- R5: A word that has started is always sent in full. A load during a word only updates the holding register, and the last word held at the word boundary is the one sent next.
- R6: When no new load occurs, the word last moved into the shift register is sent again and again without a gap.
- R7: While `oce` is 0, `oq` keeps its value. The bit slots keep advancing and loads are still captured. When `oce` returns to 1, `oq` shows the stream at its current position.
- R8: Loading the bitwise complement of a constant pattern gives the complement output stream, which for an alternating pattern is the same clock shifted by 180 degrees.
- R9: A reset in the middle of a stream returns `oq` to `OQ_RST`. The output stays there until a new load, which again starts with an eight-bit zero flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one cycle per serial half-period |
| rst | input | 1 | Synchronous active-high reset |
| div_clk | input | 1 | Parallel load clock at one eighth of `clk`, sampled in the `clk` domain |
| d_in | input | 8 | Parallel word; bit 0 is sent first |
| oce | input | 1 | Output clock-enable for the serial output register |
| oq | output | 1 | Serial output bit |

## Verification
Each result has a fixed distance in `clk` edges from its cause. The first data bit comes 9 edges after the load edge, and the flush zeros come 1 to 8 edges after it. A word loaded at edge L appears 9 to 16 edges later. An `oce` change and a reset each act at the next edge. The bench drives every input at a falling edge and reads `oq` at the following falling edge, so each observation reflects exactly one rising edge. Expected values are indexed by the number of calls since the load call, using these fixed offsets. A second instance with the opposite reset value separates the idle level from the flush zeros.

// File: rtl/dws_pkg.sv
package dws_pkg;

    // Lane word width; the serializer is defined for an 8:1 ratio only.
    localparam int unsigned LANE_BITS = 8;
    localparam int unsigned SLOT_W    = $clog2(LANE_BITS);

    typedef logic [LANE_BITS-1:0] lane_word_t;
    typedef logic [SLOT_W-1:0]    slot_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;

    // Shift controller context: state, current slot and the word in flight.
    typedef struct packed {
        ser_state_e state;
        slot_t      slot;
        lane_word_t shreg;
    } ser_ctx_t;

    localparam slot_t LAST_SLOT = slot_t'(LANE_BITS - 1);

    function automatic logic slot_is_last(input slot_t s);
        return s == LAST_SLOT;
    endfunction

    function automatic slot_t slot_next(input slot_t s);
        return slot_t'(s + slot_t'(1));
    endfunction

endpackage

// File: rtl/dws_load_capture.sv
module dws_load_capture
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       div_clk,
    input  lane_word_t d_in,
    output logic       load_pulse,
    output lane_word_t held_word
);

    logic div_q;

    // Rising edge of the load clock as seen in the bit-clock domain.
    assign load_pulse = div_clk & ~div_q & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= 1'b0;
            held_word <= '0;
        end else begin
            div_q <= div_clk;
            if (load_pulse) begin
                held_word <= d_in;
            end
        end
    end

endmodule

// File: rtl/dws_shift_ctrl.sv
module dws_shift_ctrl
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_pulse,
    input  lane_word_t held_word,
    output logic       running,
    output slot_t      slot,
    output lane_word_t shreg,
    output logic       bit_out
);

    ser_ctx_t   ctx;
    ser_ctx_t   ctx_nxt;
    lane_word_t slot_hot;

    always_comb begin
        ctx_nxt = ctx;
        unique case (ctx.state)
            SER_IDLE: begin
                // Wait for the first load; the all-zero register is flushed first.
                if (load_pulse) begin
                    ctx_nxt.state = SER_RUN;
                    ctx_nxt.slot  = '0;
                end
            end
            SER_RUN: begin
                ctx_nxt.slot = slot_next(ctx.slot);
                // Transfer only at the word boundary: no truncation.
                if (slot_is_last(ctx.slot)) begin
                    ctx_nxt.shreg = held_word;
                end
            end
            default: ctx_nxt = ctx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state <= SER_IDLE;
            ctx.slot  <= '0;
            ctx.shreg <= '0;
        end else begin
            ctx <= ctx_nxt;
        end
    end

    // One-hot slot decode feeding an AND-OR bit select.
    for (genvar g = 0; g < LANE_BITS; g++) begin : g_slot_dec
        assign slot_hot[g] = (ctx.slot == slot_t'(g));
    end

    assign bit_out = |(ctx.shreg & slot_hot);
    assign running = (ctx.state == SER_RUN);
    assign slot    = ctx.slot;
    assign shreg   = ctx.shreg;

endmodule

// File: rtl/dws_out_stage.sv
module dws_out_stage #(
    parameter logic OQ_RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic oce,
    input  logic bit_vld,
    input  logic bit_in,
    output logic oq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            oq <= OQ_RST;
        end else if (bit_vld && oce) begin
            oq <= bit_in;
        end
    end

endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
    import dws_pkg::*;
#(
    parameter logic OQ_RST = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 div_clk,
    input  logic [LANE_BITS-1:0] d_in,
    input  logic                 oce,
    output logic                 oq
);

    logic       load_pulse;
    lane_word_t held_word;
    logic       running;
    slot_t      slot;
    lane_word_t shreg;
    logic       bit_out;

    dws_load_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .div_clk    (div_clk),
        .d_in       (d_in),
        .load_pulse (load_pulse),
        .held_word  (held_word)
    );

    dws_shift_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .load_pulse (load_pulse),
        .held_word  (held_word),
        .running    (running),
        .slot       (slot),
        .shreg      (shreg),
        .bit_out    (bit_out)
    );

    dws_out_stage #(.OQ_RST(OQ_RST)) u_out (
        .clk     (clk),
        .rst     (rst),
        .oce     (oce),
        .bit_vld (running),
        .bit_in  (bit_out),
        .oq      (oq)
    );

endmodule

// File: rtl/dws_checker.sv
module dws_checker
    import dws_pkg::*;
#(
    parameter logic OQ_RST = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       oce,
    input logic       oq,
    input lane_word_t d_in,
    input logic       load_pulse,
    input lane_word_t held_word,
    input logic       running,
    input slot_t      slot,
    input lane_word_t shreg
);

    // Set once a full non-reset cycle has passed, so $past sees reset values.
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
        armed && $past(load_pulse) |-> held_word == $past(d_in)); // R1

    AST_HELD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(load_pulse) |-> $stable(held_word)); // R1

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !running |-> oq == OQ_RST); // R2

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        armed && $past(load_pulse) |-> running); // R3

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        armed && $past(running) |-> slot == slot_next($past(slot))); // R4

    AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (rst)
        armed && $past(running) && !slot_is_last($past(slot)) |-> $stable(shreg)); // R5

    AST_BOUNDARY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        armed && $past(running) && slot_is_last($past(slot)) |-> shreg == $past(held_word)); // R6

    AST_OCE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(oce) |-> $stable(oq)); // R7

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed && $past(running) |-> running); // R9

endmodule

bind ddr_word_serializer dws_checker #(.OQ_RST(OQ_RST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .oce        (oce),
    .oq         (oq),
    .d_in       (d_in),
    .load_pulse (load_pulse),
    .held_word  (held_word),
    .running    (running),
    .slot       (slot),
    .shreg      (shreg)
);

// File: tb/tb_ddr_word_serializer.sv
module tb_ddr_word_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_clk = 1'b0;
    logic       oce = 1'b1;
    logic [7:0] d_in = 8'h00;
    logic       oq_lo;
    logic       oq_hi;
    logic       obs_lo;
    logic       obs_hi;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    ddr_word_serializer #(.OQ_RST(1'b0)) dut (
        .clk(clk), .rst(rst), .div_clk(div_clk), .d_in(d_in), .oce(oce), .oq(oq_lo)
    );

    ddr_word_serializer #(.OQ_RST(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .div_clk(div_clk), .d_in(d_in), .oce(oce), .oq(oq_hi)
    );

    // word: parallel input; stream: transmit order, first bit as MSB.
    typedef struct packed {
        logic [7:0] word;
        logic [7:0] stream;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{word: 8'h01, stream: 8'h80},
        '{word: 8'h0F, stream: 8'hF0},
        '{word: 8'h37, stream: 8'hEC},
        '{word: 8'hC8, stream: 8'h13},
        '{word: 8'h96, stream: 8'h69},
        '{word: 8'h55, stream: 8'hAA},
        '{word: 8'hAA, stream: 8'h55},
        '{word: 8'h3C, stream: 8'h3C}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Observe the result of the previous rising edge, then drive the next inputs.
    task automatic cyc(input logic r, input logic dv, input logic [7:0] w, input logic oe);
        @(negedge clk);
        obs_lo  = oq_lo;
        obs_hi  = oq_hi;
        rst     = r;
        div_clk = dv;
        d_in    = w;
        oce     = oe;
    endtask

    task automatic do_reset();
        repeat (3) cyc(1'b1, 1'b0, 8'h00, 1'b1);
        cyc(1'b0, 1'b0, 8'hFF, 1'b1);
        check("R2", "reset level lo", {7'd0, obs_lo}, 8'd0);
        check("R2", "reset level hi", {7'd0, obs_hi}, 8'd1);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0, 8'hC3, 1'b1);
            check("R2", "idle before load hi", {7'd0, obs_hi}, 8'd1);
            check("R2", "idle before load lo", {7'd0, obs_lo}, 8'd0);
        end
    endtask

    initial begin
        logic [7:0] cap_a;
        logic [7:0] cap_b;

        // ---- Table walk: R1, R3, R4, R6 ----
        do_reset();
        for (int i = 0; i < (NVEC + 2) * 8 + 2; i++) begin
            int wk;
            logic dv;
            wk = (i / 8 < NVEC) ? i / 8 : NVEC - 1;
            dv = (i / 8 < NVEC) && ((i % 8) < 4);
            cyc(1'b0, dv, TBL[wk].word, 1'b1);
            if (i == 1) begin
                check("R3", "no change at load edge", {7'd0, obs_hi}, 8'd1);
            end else if (i >= 2 && i < 10) begin
                check("R3", "flush lo", {7'd0, obs_lo}, 8'd0);
                check("R3", "flush hi", {7'd0, obs_hi}, 8'd0);
            end else if (i >= 10) begin
                int k;
                int j;
                logic e;
                k = (i - 10) / 8;
                j = (i - 10) % 8;
                if (k > NVEC - 1) k = NVEC - 1;  // R6: last word repeats
                e = TBL[k].stream[7 - j];
                check((i - 10) / 8 >= NVEC ? "R6" : "R4", "stream bit",
                      {7'd0, obs_lo}, {7'd0, e});
                check("R1", "stream bit hi", {7'd0, obs_hi}, {7'd0, e});
            end
        end

        // ---- Mid-word loads: R5, R1, R6 ----
        do_reset();
        for (int r = 0; r < 34; r++) begin
            logic dv;
            logic [7:0] w;
            logic e;
            dv = (r == 0) || (r == 3) || (r >= 12 && r <= 15);
            w  = (r < 3) ? 8'h0F : (r < 12) ? 8'hE1 : (r == 12) ? 8'h5A : 8'hFF;
            cyc(1'b0, dv, w, 1'b1);
            if (r >= 2 && r < 10) begin
                check("R3", "flush before B", {7'd0, obs_lo}, 8'd0);
            end else if (r >= 10 && r < 18) begin
                e = w_bit(8'hE1, r - 10);
                check("R5", "latest held word B sent whole", {7'd0, obs_lo}, {7'd0, e});
            end else if (r >= 18) begin
                e = w_bit(8'h5A, (r - 18) % 8);
                check("R1", "word D, junk on d_in ignored", {7'd0, obs_lo}, {7'd0, e});
            end
        end

        // ---- Output enable: R7 ----
        do_reset();
        for (int r = 0; r < 42; r++) begin
            logic dv;
            logic oe;
            logic e;
            dv = (r == 0) || (r == 24);
            oe = !(r >= 22 && r <= 26);
            cyc(1'b0, dv, (r < 24) ? 8'h0F : 8'h96, oe);
            if (r >= 10 && r <= 22) begin
                e = w_bit(8'h0F, (r - 10) % 8);
                check("R6", "repeat before freeze", {7'd0, obs_lo}, {7'd0, e});
            end else if (r >= 23 && r <= 27) begin
                e = w_bit(8'h0F, 4);
                check("R7", "frozen while oce low", {7'd0, obs_lo}, {7'd0, e});
            end else if (r >= 28 && r <= 33) begin
                e = w_bit(8'h0F, (r - 10) % 8);
                check("R7", "stream kept advancing", {7'd0, obs_lo}, {7'd0, e});
            end else if (r >= 34) begin
                e = w_bit(8'h96, r - 34);
                check("R7", "load taken while oce low", {7'd0, obs_lo}, {7'd0, e});
            end
        end

        // ---- Complement pattern: R8 ----
        do_reset();
        cap_a = '0;
        for (int r = 0; r < 18; r++) begin
            cyc(1'b0, r == 0, 8'h55, 1'b1);
            if (r >= 10) cap_a[r - 10] = obs_lo;
        end
        do_reset();
        cap_b = '0;
        for (int r = 0; r < 18; r++) begin
            cyc(1'b0, r == 0, 8'hAA, 1'b1);
            if (r >= 10) cap_b[r - 10] = obs_lo;
        end
        check("R8", "alternating pattern", cap_a, 8'h55);
        check("R8", "swapped pattern is complement", cap_b, ~cap_a);

        // ---- Reset mid-stream: R9 ----
        cyc(1'b1, 1'b0, 8'hAA, 1'b1);
        cyc(1'b0, 1'b0, 8'hAA, 1'b1);
        check("R9", "reset mid-stream hi", {7'd0, obs_hi}, 8'd1);
        check("R9", "reset mid-stream lo", {7'd0, obs_lo}, 8'd0);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b0, 8'hAA, 1'b1);
            check("R9", "held until new load", {7'd0, obs_hi}, 8'd1);
        end
        for (int r = 0; r < 18; r++) begin
            cyc(1'b0, r == 0, 8'h3C, 1'b1);
            if (r >= 2 && r < 10) begin
                check("R9", "flush again", {7'd0, obs_hi}, 8'd0);
            end else if (r >= 10) begin
                check("R9", "data after reflush", {7'd0, obs_hi},
                      {7'd0, w_bit(8'h3C, r - 10)});
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic w_bit(input logic [7:0] w, input int j);
        return w[j];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule